// File: doc/BRIEF.md
# Read-Acknowledge Interrupt Vector Selector

This block sits beside the state registers of an interrupt controller and answers the two vector-and-status reads. The registers live elsewhere. Each cycle the block sees the 64-bit pending, enable and fast-type vectors and a packed array of 4-bit source priorities. From these it forms two candidate sets. It picks a normal winner through a priority compare tree and a fast winner through a lowest-index tree.

A rising edge on a read strobe latches the matching winner. One cycle later the block presents a status word on `rd_data_o` with a single-cycle `rd_valid_o`. In that same cycle it raises a single-cycle clear request naming the winner's pending bit, so the read itself acknowledges the interrupt. The surrounding logic applies that clear to its pending register, and the interrupt outputs update from there.

Top module: `vector_ack_sel`

## Requirements
- R1: A normal candidate is a source whose pending and enable bits are 1 and whose fast-type bit is 0. Disabled sources and fast-type sources never win a normal read, whatever their priority.
- R2: The priority of source i sits in `prio_i[4*i+3:4*i]`. A normal read selects the candidate with the largest priority. Priority 0 is a valid winner when it is the only candidate.
- R3: When several normal candidates share the largest priority, the one with the highest source number wins.
- R4: A successful normal read returns the source index in bits 21:16 and its priority in bits 3:0, with all other bits 0.
- R5: A fast candidate is a source whose pending, enable and fast-type bits are all 1. A fast read selects the lowest-numbered fast candidate and returns its index in bits 5:0, with all other bits 0.
- R6: When the requested read has no candidate, the returned word is 0xFFFFFFFF and no clear is issued.
- R7: A read strobe that rises at clock edge k produces `rd_valid_o` high for exactly the cycle after edge k. When the read is successful, `clr_valid_o` is high in that same cycle, and `clr_idx_o` names the source returned in `rd_data_o`.
- R8: A strobe that stays high produces only one read. A new read needs the strobe to be low at one clock edge first.
- R9: When both strobes rise at the same edge, only the fast read is served. The normal strobe edge is dropped, and no normal source is cleared.
- R10: After synchronous reset, `rd_valid_o`, `clr_valid_o`, `rd_data_o` and `clr_idx_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 64 | Pending bit per source |
| enab_i | input | 64 | Enable bit per source |
| fast_i | input | 64 | Fast-type bit per source |
| prio_i | input | 256 | 4-bit priority per source, source i at bits 4i+3:4i |
| rd_norm_i | input | 1 | Normal vector read strobe (rising edge starts a read) |
| rd_fast_i | input | 1 | Fast vector read strobe (rising edge starts a read) |
| rd_valid_o | output | 1 | Status word valid, one cycle per read |
| rd_data_o | output | 32 | Status word |
| clr_valid_o | output | 1 | Clear request for one pending bit |
| clr_idx_o | output | 6 | Source whose pending bit is to be cleared |

## Verification
Two reads can land in one cycle when the normal and the fast strobes rise at the same edge. The bench provokes this with one normal candidate and one fast candidate pending together. It expects the fast index as the returned word and as the clear target. The normal source must still be pending, which the bench proves with a later normal read that returns that source with its priority. A strobe held high for several cycles is also judged, by counting read and clear pulses over the hold.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int VS_SRC       = 64;
  localparam int VS_PRIO_W    = 4;
  localparam int VS_DATA_W    = 32;
  localparam int VS_NORM_LSB  = 16;

  typedef enum logic {
    SEL_TIE_HIGH_PRIO = 1'b0,
    SEL_LOWEST_IDX    = 1'b1
  } vs_mode_e;
endpackage

// File: rtl/vsel_rise.sv
module vsel_rise #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  // sampled through reset too, so a strobe held across reset gives no edge
  always_ff @(posedge clk) lvl_q <= lvl_i;

  assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/vsel_tree.sv
module vsel_tree
  import vsel_pkg::*;
#(
  parameter int       N    = VS_SRC,
  parameter int       PW   = VS_PRIO_W,
  parameter vs_mode_e MODE = SEL_TIE_HIGH_PRIO
) (
  input  logic [N-1:0]           cand_i,
  input  logic [N*PW-1:0]        prio_i,
  output logic                   win_vld_o,
  output logic [$clog2(N)-1:0]   win_idx_o,
  output logic [PW-1:0]          win_prio_o
);
  localparam int LVLS = $clog2(N);
  localparam int IW   = $clog2(N);

  for (genvar l = 0; l <= LVLS; l++) begin : lvl_g
    localparam int W = N >> l;
    logic [W-1:0]  v;
    logic [PW-1:0] p [W];
    logic [IW-1:0] x [W];

    if (l == 0) begin : leaf_g
      for (genvar i = 0; i < W; i++) begin : leaf_i
        assign v[i] = cand_i[i];
        assign p[i] = prio_i[i*PW +: PW];
        assign x[i] = IW'(i);
      end
    end else begin : node_g
      for (genvar i = 0; i < W; i++) begin : node_i
        logic          lo_v, hi_v, take_hi;
        logic [PW-1:0] lo_p, hi_p;
        logic [IW-1:0] lo_x, hi_x;
        assign lo_v = lvl_g[l-1].v[2*i];
        assign hi_v = lvl_g[l-1].v[2*i+1];
        assign lo_p = lvl_g[l-1].p[2*i];
        assign hi_p = lvl_g[l-1].p[2*i+1];
        assign lo_x = lvl_g[l-1].x[2*i];
        assign hi_x = lvl_g[l-1].x[2*i+1];
        if (MODE == SEL_TIE_HIGH_PRIO) begin : prio_g
          // upper half holds higher indices: it wins on equal priority
          assign take_hi = hi_v & (~lo_v | (hi_p >= lo_p));
        end else begin : low_g
          assign take_hi = hi_v & ~lo_v;
        end
        assign v[i] = lo_v | hi_v;
        assign p[i] = take_hi ? hi_p : lo_p;
        assign x[i] = take_hi ? hi_x : lo_x;
      end
    end
  end

  assign win_vld_o  = lvl_g[LVLS].v[0];
  assign win_idx_o  = lvl_g[LVLS].x[0];
  assign win_prio_o = lvl_g[LVLS].p[0];

  always_comb begin
    // R6
    tree_any_chk: assert (win_vld_o == (|cand_i));
    // R1
    tree_live_chk: assert (!win_vld_o || cand_i[win_idx_o]);
  end
endmodule

// File: rtl/vector_ack_sel.sv
module vector_ack_sel
  import vsel_pkg::*;
#(
  parameter int N_SRC    = VS_SRC,
  parameter int PRIO_W   = VS_PRIO_W,
  parameter int DATA_W   = VS_DATA_W,
  parameter int NORM_LSB = VS_NORM_LSB
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_SRC-1:0]          pend_i,
  input  logic [N_SRC-1:0]          enab_i,
  input  logic [N_SRC-1:0]          fast_i,
  input  logic [N_SRC*PRIO_W-1:0]   prio_i,
  input  logic                      rd_norm_i,
  input  logic                      rd_fast_i,
  output logic                      rd_valid_o,
  output logic [DATA_W-1:0]         rd_data_o,
  output logic                      clr_valid_o,
  output logic [$clog2(N_SRC)-1:0]  clr_idx_o
);
  localparam int IDX_W = $clog2(N_SRC);
  localparam logic [DATA_W-1:0] EMPTY_WORD = '1;

  logic [N_SRC-1:0]  live, norm_cand, fast_cand;
  logic              norm_vld, fast_vld;
  logic [IDX_W-1:0]  norm_idx, fast_idx;
  logic [PRIO_W-1:0] norm_prio, fast_prio;
  logic [1:0]        rise;
  logic              acc_n, acc_f;
  logic [DATA_W-1:0] norm_word, fast_word;

  assign live      = pend_i & enab_i;
  assign norm_cand = live & ~fast_i;
  assign fast_cand = live & fast_i;

  vsel_tree #(.N(N_SRC), .PW(PRIO_W), .MODE(SEL_TIE_HIGH_PRIO)) u_norm_tree (
    .cand_i    (norm_cand),
    .prio_i    (prio_i),
    .win_vld_o (norm_vld),
    .win_idx_o (norm_idx),
    .win_prio_o(norm_prio)
  );

  vsel_tree #(.N(N_SRC), .PW(PRIO_W), .MODE(SEL_LOWEST_IDX)) u_fast_tree (
    .cand_i    (fast_cand),
    .prio_i    (prio_i),
    .win_vld_o (fast_vld),
    .win_idx_o (fast_idx),
    .win_prio_o(fast_prio)
  );

  wire unused_fast_prio = ^fast_prio;

  vsel_rise #(.W(2)) u_rise (
    .clk   (clk),
    .lvl_i ({rd_fast_i, rd_norm_i}),
    .rise_o(rise)
  );

  // fast read takes precedence when both strobes rise together
  assign acc_f = rise[1];
  assign acc_n = rise[0] & ~rise[1];

  assign norm_word = (DATA_W'(norm_idx) << NORM_LSB) | DATA_W'(norm_prio);
  assign fast_word = DATA_W'(fast_idx);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
      clr_valid_o <= 1'b0;
      clr_idx_o   <= '0;
    end else begin
      rd_valid_o  <= acc_n | acc_f;
      clr_valid_o <= (acc_f & fast_vld) | (acc_n & norm_vld);
      if (acc_f) begin
        rd_data_o <= fast_vld ? fast_word : EMPTY_WORD;
        if (fast_vld) clr_idx_o <= fast_idx;
      end else if (acc_n) begin
        rd_data_o <= norm_vld ? norm_word : EMPTY_WORD;
        if (norm_vld) clr_idx_o <= norm_idx;
      end
    end
  end

  // R7
  clr_with_read_chk: assert property (@(posedge clk) disable iff (rst)
    clr_valid_o |-> (rd_valid_o && rd_data_o != EMPTY_WORD));

  // R6
  empty_no_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && rd_data_o == EMPTY_WORD) |-> !clr_valid_o);

  // R7
  clr_was_live_chk: assert property (@(posedge clk) disable iff (rst)
    clr_valid_o |-> ((($past(live)) >> clr_idx_o) & 1) != 0);

  // R8
  held_once_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_norm_i && $past(rd_norm_i) && !rd_fast_i && !$past(rd_fast_i)) |=> !rd_valid_o);

  // R4
  word_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid_o && rd_data_o != EMPTY_WORD) |->
      (rd_data_o[DATA_W-1:NORM_LSB+IDX_W] == '0 && rd_data_o[NORM_LSB-1:IDX_W] == '0));

  // R7
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rd_norm_i) && !$past(rd_fast_i)) |-> !rd_valid_o);
endmodule

// File: tb/vector_ack_sel_tb.sv
`timescale 1ns/1ps
module vector_ack_sel_tb;
  localparam real CLK_NS = 8.0;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [63:0]  pend = '0, enab = '0, fast = '0;
  logic [255:0] prio = '0;
  logic         rd_norm = 1'b0, rd_fast = 1'b0;
  logic         rd_valid, clr_valid;
  logic [31:0]  rd_data;
  logic [5:0]   clr_idx;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  vector_ack_sel u_dut (
    .clk(clk), .rst(rst), .pend_i(pend), .enab_i(enab), .fast_i(fast),
    .prio_i(prio), .rd_norm_i(rd_norm), .rd_fast_i(rd_fast),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .clr_valid_o(clr_valid), .clr_idx_o(clr_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_state();
    pend = '0; enab = '0; fast = '0; prio = '0;
  endtask

  task automatic add_src(input int i, input logic [3:0] p, input bit is_fast);
    pend[i] = 1'b1; enab[i] = 1'b1; fast[i] = is_fast; prio[4*i +: 4] = p;
  endtask

  // one read: strobe high for one edge, sample the cycle after, apply the clear
  task automatic do_read(input bit is_fast, input string req, input logic [31:0] exp_data);
    logic [31:0] d;
    logic        cv;
    logic [5:0]  ci;
    @(negedge clk);
    if (is_fast) rd_fast = 1'b1; else rd_norm = 1'b1;
    @(negedge clk);
    rd_fast = 1'b0; rd_norm = 1'b0;
    d = rd_data; cv = clr_valid; ci = clr_idx;
    chk(rd_valid === 1'b1, {req, " R7 rd_valid"}, 32'(rd_valid), 32'd1);
    chk(d === exp_data, {req, " data"}, d, exp_data);
    if (exp_data == 32'hFFFF_FFFF) begin
      chk(cv === 1'b0, {req, " R6 no clear"}, 32'(cv), 32'd0);
    end else begin
      chk(cv === 1'b1, {req, " R7 clear"}, 32'(cv), 32'd1);
      chk(32'(ci) == (is_fast ? exp_data : 32'(exp_data[21:16])), {req, " R7 clr_idx"},
          32'(ci), is_fast ? exp_data : 32'(exp_data[21:16]));
      pend[ci] = 1'b0;
    end
    @(negedge clk);
    chk(rd_valid === 1'b0 && clr_valid === 1'b0, {req, " R7 single pulse"},
        {30'd0, rd_valid, clr_valid}, 32'd0);
  endtask

  task automatic t_reset();
    chk(rd_valid === 1'b0, "R10 rd_valid", 32'(rd_valid), 0);
    chk(clr_valid === 1'b0, "R10 clr_valid", 32'(clr_valid), 0);
    chk(rd_data === 32'd0, "R10 rd_data", rd_data, 0);
    chk(clr_idx === 6'd0, "R10 clr_idx", 32'(clr_idx), 0);
  endtask

  task automatic t_norm_basic();
    clear_state();
    add_src(3, 4'd5, 0); add_src(10, 4'd9, 0); add_src(40, 4'd2, 0);
    pend[20] = 1'b1; prio[80 +: 4] = 4'hF;   // pending, not enabled
    add_src(21, 4'hF, 1);                    // fast type
    do_read(0, "R2 R1 top prio", 32'h000A_0009);
    do_read(0, "R2 R4 next", 32'h0003_0005);
    do_read(0, "R2 last", 32'h0028_0002);
    do_read(0, "R1 R6 only excluded left", 32'hFFFF_FFFF);
  endtask

  task automatic t_tie();
    clear_state();
    add_src(5, 4'd7, 0); add_src(50, 4'd7, 0); add_src(30, 4'd6, 0);
    do_read(0, "R3 tie high idx", 32'h0032_0007);
    do_read(0, "R3 tie remaining", 32'h0005_0007);
    do_read(0, "R2 lower prio", 32'h001E_0006);
    do_read(0, "R6 normal empty", 32'hFFFF_FFFF);
  endtask

  task automatic t_fast();
    clear_state();
    add_src(33, 4'd1, 1); add_src(60, 4'hF, 1); add_src(12, 4'd0, 1);
    pend[2] = 1'b1; fast[2] = 1'b1;          // not enabled
    add_src(1, 4'hF, 0);
    do_read(1, "R5 lowest", 32'h0000_000C);
    do_read(1, "R5 next", 32'h0000_0021);
    do_read(1, "R5 high prio ignored", 32'h0000_003C);
    do_read(1, "R6 fast empty", 32'hFFFF_FFFF);
    do_read(0, "R1 normal survives fast reads", 32'h0001_000F);
  endtask

  task automatic t_prio0();
    clear_state();
    add_src(63, 4'd0, 0);
    do_read(0, "R2 prio zero wins", 32'h003F_0000);
  endtask

  task automatic t_held();
    int nv = 0;
    int nc = 0;
    clear_state();
    add_src(7, 4'd1, 0); add_src(8, 4'd1, 0);
    @(negedge clk);
    rd_norm = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (rd_valid) nv++;
      if (clr_valid) begin nc++; pend[clr_idx] = 1'b0; end
    end
    rd_norm = 1'b0;
    @(negedge clk);
    if (rd_valid) nv++;
    chk(nv == 1, "R8 reads while held", nv, 1);
    chk(nc == 1, "R8 clears while held", nc, 1);
    chk(pend[7] === 1'b1, "R8 source 7 untouched", 32'(pend[7]), 1);
    do_read(0, "R8 new read after low", 32'h0007_0001);
  endtask

  task automatic t_both();
    clear_state();
    add_src(9, 4'd3, 0); add_src(44, 4'd2, 1);
    @(negedge clk);
    rd_norm = 1'b1; rd_fast = 1'b1;
    @(negedge clk);
    rd_norm = 1'b0; rd_fast = 1'b0;
    chk(rd_valid === 1'b1, "R9 one read", 32'(rd_valid), 1);
    chk(rd_data === 32'h0000_002C, "R9 fast served", rd_data, 32'h2C);
    chk(clr_valid === 1'b1 && clr_idx == 6'd44, "R9 fast cleared",
        {25'd0, clr_valid, clr_idx}, {25'd0, 1'b1, 6'd44});
    if (clr_valid) pend[clr_idx] = 1'b0;
    @(negedge clk);
    chk(rd_valid === 1'b0, "R9 no second read", 32'(rd_valid), 0);
    do_read(0, "R9 normal still pending", 32'h0009_0003);
  endtask

  initial begin
    #(CLK_NS * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_norm_basic();
    t_tie();
    t_fast();
    t_prio0();
    t_held();
    t_both();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule